// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block produces four independent pulse-width modulated outputs from one input clock. Each channel has three registers: a control word, a high-time count and a cycle-length count. The control word holds the channel's run bit and a 14-bit clock divider. The divider slows the count so that one count step lasts (divider+1) input clocks. The output is driven high at the start of each cycle, stays high for the high-time count and is low for the rest of the cycle. A single global run register gates all four channels, so software can configure every channel and then start them together.

Software reaches the registers through a plain synchronous port with an address, write data, a write strobe and read data. Each channel's registers sit in a 16-byte slot, and the global register sits at the top of the last slot. Changes to the high-time and cycle-length counts made while a channel is running are held back until the current cycle ends, so the output never shows a truncated or stretched pulse.

Top module: `pwm_quad_top`

## Requirements
- R1: Channel n (0..3) uses byte addresses n*0x10 + offset: offset 0x0 is control, 0x4 is the high-time count and 0x8 is the cycle-length count. The global run register is at 0x3C, with the run flag in bit 0.
- R2: Control bit 0 is the channel run flag and bits [15:2] are the 14-bit divider. All other control bits read as zero. The two counts are 16 bits wide. Every register reads back its last written value in read data one clock after the address is presented.
- R3: Addresses that map to no register read as zero, and writes to them have no effect. This covers offset 0xC of channels 0 to 2 and every address from 0x40 up.
- R4: Reset is synchronous and active high. It clears every register to zero and drives all outputs low.
- R5: An output can be high only while both the global run flag and its own channel's run flag are set. Otherwise it is held low.
- R6: Once a channel starts, its output goes high in the first clock after the enabling write. One cycle lasts (divider+1)*length input clocks, and the output is high for the first (divider+1)*high-time of them.
- R7: If the high-time count is greater than or equal to the cycle length, the output stays high for the entire cycle.
- R8: High-time and cycle-length values written while a channel runs take effect only from the next cycle boundary. The cycle in progress finishes with the old values.
- R9: Clearing either run flag resets the channel's divider and cycle counters. When the channel is enabled again, it starts a fresh cycle with its high phase.
- R10: Channels run independently. Two channels started by the same global enable each follow their own divider and counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the counters and the register port |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_rdata | output | 32 | Registered read data for the previous address |
| pwm_out | output | 4 | PWM outputs, one bit per channel |

## Verification
The output is sampled every clock over whole windows. Each window records the number of high clocks and the number of rising transitions, which separates a wrong high time from a wrong cycle length. The patterns used are:
- divider zero with a 2-of-4 ratio;
- a divider of two with a 1-of-3 ratio, which shows whether the divider multiplies both counts;
- a high time above the cycle length, which must give a single rise;
- new counts written in the middle of a cycle, where taking effect at once gives one extra high clock.

Separate runs hold one channel off by the global flag alone, stop and restart a channel part way through a cycle to expose counters that freeze instead of clearing, and start two channels with different settings from one global write.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

    localparam int NUM_CH  = 4;
    localparam int CNT_W   = 16;
    localparam int PSC_W   = 14;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int SLOT_LG = 4;

    localparam logic [3:0]        OFF_CTRL   = 4'h0;
    localparam logic [3:0]        OFF_HIGH   = 4'h4;
    localparam logic [3:0]        OFF_LENGTH = 4'h8;
    localparam logic [ADDR_W-1:0] GLOBAL_ADDR = 8'h3C;

    typedef struct packed {
        logic             run;
        logic [PSC_W-1:0] div;
        logic [CNT_W-1:0] high;
        logic [CNT_W-1:0] length;
    } ch_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] high;
        logic [CNT_W-1:0] length;
    } shape_t;

    typedef enum logic [1:0] {
        SEL_CTRL,
        SEL_HIGH,
        SEL_LENGTH,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [3:0] off);
        case (off)
            OFF_CTRL:   return SEL_CTRL;
            OFF_HIGH:   return SEL_HIGH;
            OFF_LENGTH: return SEL_LENGTH;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ch_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = c.run;
        w[PSC_W+1:2] = c.div;
        return w;
    endfunction

endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
    import pwm_quad_pkg::*;
#(
    parameter int N_CH   = NUM_CH,
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    output logic [DW-1:0] rdata,
    output ch_cfg_t       cfg [N_CH],
    output logic          global_run
);

    localparam int CH_LG = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic [CH_LG-1:0] ch_idx;
    logic             in_range;
    logic             hit_global;
    reg_sel_e         sel;
    logic [DW-1:0]    rd_next;
    logic             unused_wbits;

    assign ch_idx     = addr[SLOT_LG +: CH_LG];
    assign in_range   = (addr >> (SLOT_LG + CH_LG)) == '0;
    assign hit_global = (addr == GLOBAL_ADDR);
    assign sel        = decode_offset(addr[3:0]);
    assign unused_wbits = ^wdata[DW-1:CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            global_run <= 1'b0;
        end else if (we && hit_global) begin
            global_run <= wdata[0];
        end
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_ch_regs
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[i] <= '0;
            end else if (we && in_range && ch_idx == CH_LG'(i)) begin
                case (sel)
                    SEL_CTRL: begin
                        cfg[i].run <= wdata[0];
                        cfg[i].div <= wdata[PSC_W+1:2];
                    end
                    SEL_HIGH:   cfg[i].high   <= wdata[CNT_W-1:0];
                    SEL_LENGTH: cfg[i].length <= wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_next = '0;
        if (hit_global) begin
            rd_next[0] = global_run;
        end else if (in_range) begin
            case (sel)
                SEL_CTRL:   rd_next = pack_ctrl(cfg[ch_idx]);
                SEL_HIGH:   rd_next[CNT_W-1:0] = cfg[ch_idx].high;
                SEL_LENGTH: rd_next[CNT_W-1:0] = cfg[ch_idx].length;
                default:    rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_next;
    end

endmodule

// File: rtl/pwm_quad_channel.sv
module pwm_quad_channel
    import pwm_quad_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PSC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [PW-1:0] div,
    input  logic [CW-1:0] high_cfg,
    input  logic [CW-1:0] length_cfg,
    output logic          pwm_o
);

    logic [PW-1:0] div_cnt;
    logic [CW-1:0] cyc_cnt;
    shape_t        active;
    logic          step;
    logic          wrap;

    assign step = (div_cnt >= div);
    assign wrap = step && (({1'b0, cyc_cnt} + (CW+1)'(1)) >= {1'b0, active.length});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_cnt       <= '0;
            cyc_cnt       <= '0;
            active.high   <= high_cfg;
            active.length <= length_cfg;
        end else begin
            div_cnt <= step ? '0 : div_cnt + PW'(1);
            if (wrap) begin
                cyc_cnt       <= '0;
                active.high   <= high_cfg;
                active.length <= length_cfg;
            end else if (step) begin
                cyc_cnt <= cyc_cnt + CW'(1);
            end
        end
    end

    assign pwm_o = run && (cyc_cnt < active.high);

endmodule

// File: rtl/pwm_quad_top.sv
module pwm_quad_top
    import pwm_quad_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    output logic [DW-1:0] bus_rdata,
    output logic [N_CH-1:0] pwm_out
);

    ch_cfg_t         cfg [N_CH];
    logic            global_run;
    logic [N_CH-1:0] ch_run;

    pwm_quad_regs #(
        .N_CH(N_CH),
        .AW  (AW),
        .DW  (DW)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .we        (bus_we),
        .rdata     (bus_rdata),
        .cfg       (cfg),
        .global_run(global_run)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        assign ch_run[i] = global_run && cfg[i].run;

        pwm_quad_channel #(
            .CW(CNT_W),
            .PW(PSC_W)
        ) u_channel (
            .clk       (clk),
            .rst       (rst),
            .run       (ch_run[i]),
            .div       (cfg[i].div),
            .high_cfg  (cfg[i].high),
            .length_cfg(cfg[i].length),
            .pwm_o     (pwm_out[i])
        );
    end

endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
    parameter int N_CH = 4,
    parameter int AW   = 8,
    parameter int DW   = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic            bus_we,
    input logic [DW-1:0]   bus_rdata,
    input logic [N_CH-1:0] pwm_out,
    input logic            global_run
);

    // R3
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= AW'(8'h40)) |=> (bus_rdata == '0));

    // R2
    ctrl_spare_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[3:0] == 4'h0 && bus_addr < AW'(8'h40)) |=>
            (bus_rdata[DW-1:16] == '0 && bus_rdata[1] == 1'b0));

    // R1
    global_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == AW'(8'h3C)) |=> (global_run == $past(bus_wdata[0])));

    // R5
    global_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !global_run |-> (pwm_out == '0));

    // R4
    reset_read_zero_chk: assert property (@(posedge clk)
        $past(rst) && rst |-> (bus_rdata == '0 && pwm_out == '0));

endmodule

bind pwm_quad_top pwm_quad_chk #(
    .N_CH(N_CH),
    .AW  (AW),
    .DW  (DW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .global_run(global_run)
);

// File: tb/pwm_quad_top_tb.sv
`timescale 1ns/1ps
module pwm_quad_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_quad_top u_dut (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .bus_rdata(bus_rdata),
        .pwm_out  (pwm_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    // samples from the current negedge for len clocks
    task automatic measure(input int ch, input int len, input int exp_hi,
                           input int exp_rise, input string tag);
        int hi = 0, rise = 0;
        logic prev = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (pwm_out[ch]) hi++;
            if (pwm_out[ch] && !prev) rise++;
            prev = pwm_out[ch];
            @(negedge clk);
        end
        chk({tag, " high clocks"}, hi, exp_hi);
        chk({tag, " rises"}, rise, exp_rise);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R4 outputs after reset", {28'b0, pwm_out}, 32'h0);
        rd(8'h00, v); chk("R4 ch0 ctrl", v, 0);
        rd(8'h24, v); chk("R4 ch2 high", v, 0);
        rd(8'h38, v); chk("R4 ch3 length", v, 0);
        rd(8'h3C, v); chk("R4 global", v, 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R2 ctrl spare bits", v, 32'h0000_FFFD);
        wr(8'h10, 32'h0);
        wr(8'h24, 32'hABCD_1234);
        wr(8'h28, 32'h5555_9876);
        wr(8'h20, 32'h0000_1235);
        rd(8'h24, v); chk("R1 ch2 high slot", v, 32'h1234);
        rd(8'h28, v); chk("R1 ch2 length slot", v, 32'h9876);
        rd(8'h20, v); chk("R2 ch2 ctrl divider", v, 32'h1235);
        rd(8'h04, v); chk("R1 ch0 untouched", v, 0);
        wr(8'h20, 32'h0); wr(8'h24, 32'h0); wr(8'h28, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'h0C, v); chk("R3 slot offset C", v, 0);
        rd(8'h40, v); chk("R3 above map", v, 0);
        rd(8'hFC, v); chk("R3 top address", v, 0);
        rd(8'h3C, v); chk("R3 global unchanged", v, 0);
        rd(8'h00, v); chk("R3 ch0 ctrl unchanged", v, 0);
    endtask

    task automatic t_gate_and_basic();
        int hi = 0;
        wr(8'h04, 2); wr(8'h08, 4); wr(8'h00, 1);
        for (int i = 0; i < 16; i++) begin
            if (pwm_out[0]) hi++;
            @(negedge clk);
        end
        chk("R5 global off keeps output low", hi, 0);
        wr(8'h3C, 1);
        measure(0, 12, 6, 3, "R6 div0 2of4");
    endtask

    task automatic t_divider();
        wr(8'h00, 0); wr(8'h04, 1); wr(8'h08, 3);
        wr(8'h00, (2 << 2) | 1);
        measure(0, 18, 6, 2, "R6 div2 1of3");
    endtask

    task automatic t_full_high();
        wr(8'h00, 0); wr(8'h04, 5); wr(8'h08, 3);
        wr(8'h00, 1);
        measure(0, 9, 9, 1, "R7 high beyond length");
    endtask

    task automatic t_shadow();
        int hi = 0;
        wr(8'h00, 0); wr(8'h04, 2); wr(8'h08, 4);
        wr(8'h00, 1);
        for (int i = 0; i < 14; i++) begin
            if (pwm_out[0]) hi++;
            if (i == 1) begin bus_addr = 8'h04; bus_wdata = 3; bus_we = 1'b1; end
            if (i == 2) begin bus_addr = 8'h08; bus_wdata = 5; bus_we = 1'b1; end
            if (i == 3) bus_we = 1'b0;
            @(negedge clk);
        end
        chk("R8 update at boundary", hi, 8);
    endtask

    task automatic t_restart();
        int hi = 0;
        wr(8'h00, 0); wr(8'h04, 2); wr(8'h08, 4);
        wr(8'h00, 1);
        repeat (4) @(negedge clk);
        wr(8'h00, 0);
        for (int i = 0; i < 3; i++) begin
            if (pwm_out[0]) hi++;
            @(negedge clk);
        end
        chk("R9 low while stopped", hi, 0);
        wr(8'h00, 1);
        chk("R9 fresh cycle starts high", pwm_out[0], 1);
        measure(0, 4, 2, 1, "R9 restart phase");
    endtask

    task automatic t_independent();
        int hi1 = 0, hi2 = 0, r1 = 0, r2 = 0;
        logic p1 = 1'b0, p2 = 1'b0;
        wr(8'h3C, 0); wr(8'h00, 0);
        wr(8'h14, 1); wr(8'h18, 2); wr(8'h10, 1);
        wr(8'h24, 2); wr(8'h28, 3); wr(8'h20, (1 << 2) | 1);
        wr(8'h3C, 1);
        for (int i = 0; i < 12; i++) begin
            if (pwm_out[1]) hi1++;
            if (pwm_out[2]) hi2++;
            if (pwm_out[1] && !p1) r1++;
            if (pwm_out[2] && !p2) r2++;
            p1 = pwm_out[1]; p2 = pwm_out[2];
            @(negedge clk);
        end
        chk("R10 ch1 high clocks", hi1, 6);
        chk("R10 ch1 rises", r1, 6);
        chk("R10 ch2 high clocks", hi2, 8);
        chk("R10 ch2 rises", r2, 2);
        chk("R10 ch0 idle", pwm_out[0], 0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_unmapped();
        t_gate_and_basic();
        t_divider();
        t_full_high();
        t_shadow();
        t_restart();
        t_independent();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule